// File: doc/BRIEF.md
# Synchronous SRAM Read Output Pipeline

This block sits between the read port of a synchronous SRAM core and its data pins. Each clock the front end hands it a command class (read, write or deselect) together with the word coming out of the storage array. It then decides when a word is placed on the bus and when the bus is released. The bus is modelled as an enable flag and a data value, and the value reads as zero whenever the enable is low.

A static select input picks between two output modes:

- **Flow-through mode.** The array word goes straight to the bus in the cycle after its read command is sampled.
- **Pipelined mode.** The word first passes through a rising-edge register, which adds one cycle of latency.

A deselect travels through exactly the same stages as a read. In pipelined mode, a deselect that follows a read therefore leaves the bus driven for one more full cycle and releases it only after the second rising edge. Board designs should pull the select high, so that pipelined mode is what an unconnected select gives.

Output enable and sleep act on the bus enable without waiting for a clock. Sleep also flushes both command stages to OFF, so commands that arrive during sleep are dropped. Sleep leaves the captured output word untouched.

Each command stage holds one slot class: OFF, READ or WRITE. The command stage moves as follows on every edge:

- It goes to READ on a read command.
- It goes to WRITE on a write command.
- It goes to OFF on a deselect, or whenever sleep is high.

The output stage takes the class held by the command stage, or goes to OFF while sleep is high. It captures the array word each time it moves to READ.

Top module: `sram_rd_outpipe`

## Requirements
- R1: After reset both stages hold OFF and `dq_en` is low until a read has propagated.
- R2: With `pipe_sel`=0 (flow-through), a read (`cmd`=2'b01) sampled at edge k drives `dq_en` high in the cycle after edge k, with `dq_out` following `array_rdata` combinationally during that cycle.
- R3: With `pipe_sel`=1 (pipelined), a read sampled at edge k drives `dq_en` high in the cycle after edge k+1, and `dq_out` equals the `array_rdata` value present at edge k+1.
- R4: Consecutive reads put one new word on the bus every cycle in either mode. The first word appears one cycle later in pipelined mode than in flow-through mode.
- R5: In pipelined mode a deselect (`cmd`=2'b00 or 2'b11) sampled at edge k right after a read keeps the bus driven until edge k+1 and releases it after edge k+1.
- R6: A write (`cmd`=2'b10) sampled at edge k holds `dq_en` low in the following cycle in both modes, including when an earlier pipelined read would otherwise be driving.
- R7: `oe` low forces `dq_en` low at once, with no clock edge needed. Raising `oe` again restores the drive the pipeline state calls for.
- R8: `sleep` high forces `dq_en` low at once. Commands sampled while `sleep` is high are ignored. After release the bus stays off until a read sampled after release has propagated.
- R9: `dq_out` reads zero in every cycle in which `dq_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pipe_sel | input | 1 | Static mode select: 1 pipelined, 0 flow-through |
| cmd | input | 2 | Command class: 01 read, 10 write, 00/11 deselect |
| array_rdata | input | W | Word from the storage array, valid in the cycle after its read |
| oe | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Asynchronous sleep, active high |
| dq_en | output | 1 | Bus driver enable |
| dq_out | output | W | Bus data, zero when not enabled |

## Verification
The bench targets these corner cases:

- **Read followed by a deselect in pipelined mode.** A design that releases too early loses the last word. A design that never pipelines the deselect holds the bus a cycle too long.
- **A write right after a pipelined read.** Without the write override, the driver fights the incoming write data.
- **Sleep lasting exactly one edge, followed by release.** A design that flushes only the command stage replays a stale read from the output stage.
- **Toggling `oe` and `sleep` mid-cycle.** This exposes any enable path that waits for a clock.
- **Both modes under a long mixed command stream.** This catches off-by-one latency and output registers that capture on the wrong slot.

// File: rtl/srp_pkg.sv
package srp_pkg;
    typedef enum logic [1:0] {
        SLOT_OFF   = 2'b00,
        SLOT_READ  = 2'b01,
        SLOT_WRITE = 2'b10
    } slot_e;

    localparam logic [1:0] CMD_DESEL = 2'b00;
    localparam logic [1:0] CMD_READ  = 2'b01;
    localparam logic [1:0] CMD_WRITE = 2'b10;
endpackage

// File: rtl/srp_cmd_decode.sv
module srp_cmd_decode
    import srp_pkg::*;
(
    input  logic [1:0] cmd,
    input  logic       sleep,
    output slot_e      slot_nxt
);
    always_comb begin
        slot_nxt = SLOT_OFF;
        if (!sleep) begin
            unique case (cmd)
                CMD_READ:  slot_nxt = SLOT_READ;
                CMD_WRITE: slot_nxt = SLOT_WRITE;
                default:   slot_nxt = SLOT_OFF;
            endcase
        end
    end
endmodule

// File: rtl/srp_out_reg.sv
module srp_out_reg
    import srp_pkg::*;
#(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  slot_e        slot_in,
    input  logic [W-1:0] data_in,
    output slot_e        slot_q,
    output logic [W-1:0] data_q
);
    // slot register
    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= SLOT_OFF;
        else        slot_q <= slot_in;
    end

    // word register: loads only when a read enters this stage
    always_ff @(posedge clk) begin
        if (!rst_n)                    data_q <= '0;
        else if (slot_in == SLOT_READ) data_q <= data_in;
    end
endmodule

// File: rtl/srp_drive_ctl.sv
module srp_drive_ctl
    import srp_pkg::*;
#(
    parameter int W = 36
) (
    input  logic         pipe_sel,
    input  logic         oe,
    input  logic         sleep,
    input  slot_e        slot_a,
    input  slot_e        slot_b,
    input  logic [W-1:0] flow_word,
    input  logic [W-1:0] reg_word,
    output logic         dq_en,
    output logic [W-1:0] dq_out
);
    logic         live;
    logic [W-1:0] word;

    always_comb begin
        unique case (pipe_sel)
            1'b1: begin
                live = (slot_b == SLOT_READ) && (slot_a != SLOT_WRITE);
                word = reg_word;
            end
            default: begin
                live = (slot_a == SLOT_READ);
                word = flow_word;
            end
        endcase
        dq_en  = live && oe && !sleep;
        dq_out = dq_en ? word : '0;
    end
endmodule

// File: rtl/sram_rd_outpipe.sv
module sram_rd_outpipe
    import srp_pkg::*;
#(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pipe_sel,
    input  logic [1:0]   cmd,
    input  logic [W-1:0] array_rdata,
    input  logic         oe,
    input  logic         sleep,
    output logic         dq_en,
    output logic [W-1:0] dq_out
);
    slot_e        a_nxt;
    slot_e        a_q;
    slot_e        b_nxt;
    slot_e        b_q;
    logic [W-1:0] b_word;

    srp_cmd_decode u_dec (
        .cmd      (cmd),
        .sleep    (sleep),
        .slot_nxt (a_nxt)
    );

    // command stage state register
    always_ff @(posedge clk) begin
        if (!rst_n) a_q <= SLOT_OFF;
        else        a_q <= a_nxt;
    end

    // sleep flushes the output stage as well, so nothing stale survives
    always_comb begin
        unique case (sleep)
            1'b1:    b_nxt = SLOT_OFF;
            default: b_nxt = a_q;
        endcase
    end

    srp_out_reg #(.W(W)) u_oreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .slot_in (b_nxt),
        .data_in (array_rdata),
        .slot_q  (b_q),
        .data_q  (b_word)
    );

    srp_drive_ctl #(.W(W)) u_drv (
        .pipe_sel  (pipe_sel),
        .oe        (oe),
        .sleep     (sleep),
        .slot_a    (a_q),
        .slot_b    (b_q),
        .flow_word (array_rdata),
        .reg_word  (b_word),
        .dq_en     (dq_en),
        .dq_out    (dq_out)
    );
endmodule

// File: rtl/srp_checker.sv
module srp_checker
    import srp_pkg::*;
#(
    parameter int W = 36
) (
    input logic         clk,
    input logic         rst_n,
    input logic         pipe_sel,
    input logic [1:0]   cmd,
    input logic [W-1:0] array_rdata,
    input logic         oe,
    input logic         sleep,
    input logic         dq_en,
    input logic [W-1:0] dq_out
);
    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_en |-> (dq_out == '0));

    // R7
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> !dq_en);

    // R8
    sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dq_en);

    // R6
    write_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WRITE && !sleep) |=> !dq_en);

    // R2
    flow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_sel && $past(rst_n) && $past(cmd == CMD_READ && !sleep) && oe && !sleep)
        |-> (dq_en && dq_out == array_rdata));

    // R3
    pipe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_sel && $past(rst_n, 2) && $past(cmd == CMD_READ && !sleep, 2)
         && $past(!sleep) && $past(cmd != CMD_WRITE) && oe && !sleep)
        |-> dq_en);

    // R5
    pipe_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_sel && $past(cmd != CMD_READ, 2)) |-> !dq_en);
endmodule

bind sram_rd_outpipe srp_checker #(.W(W)) u_srp_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pipe_sel    (pipe_sel),
    .cmd         (cmd),
    .array_rdata (array_rdata),
    .oe          (oe),
    .sleep       (sleep),
    .dq_en       (dq_en),
    .dq_out      (dq_out)
);

// File: tb/sram_rd_outpipe_bench.sv
module sram_rd_outpipe_bench;
    localparam int W = 36;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pipe_sel = 1'b1;
    logic [1:0]   cmd = 2'b00;
    logic [W-1:0] array_rdata = '0;
    logic         oe = 1'b1;
    logic         sleep = 1'b0;
    logic         dq_en;
    logic [W-1:0] dq_out;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // reference model state: classes 0 off, 1 read, 2 write
    int           hist_a[$];
    int           hist_b[$];
    logic [W-1:0] m_word;

    always #5 clk = ~clk;

    sram_rd_outpipe #(.W(W)) u_sram_rd_outpipe (
        .clk(clk), .rst_n(rst_n), .pipe_sel(pipe_sel), .cmd(cmd),
        .array_rdata(array_rdata), .oe(oe), .sleep(sleep),
        .dq_en(dq_en), .dq_out(dq_out)
    );

    function automatic int cls(input logic [1:0] c);
        if (c == 2'b01) return 1;
        if (c == 2'b10) return 2;
        return 0;
    endfunction

    task automatic model_clear();
        hist_a.delete();
        hist_b.delete();
        hist_a.push_front(0);
        hist_b.push_front(0);
        m_word = '0;
    endtask

    task automatic model_edge();
        int ea;
        int eb;
        ea = sleep ? 0 : cls(cmd);
        eb = sleep ? 0 : hist_a[0];
        if (eb == 1) m_word = array_rdata;
        hist_a.push_front(ea);
        hist_b.push_front(eb);
    endtask

    task automatic compare(input string tag);
        logic         e_en;
        logic [W-1:0] e_out;
        if (pipe_sel)
            e_en = oe && !sleep && hist_b[0] == 1 && hist_a[0] != 2;
        else
            e_en = oe && !sleep && hist_a[0] == 1;
        e_out = e_en ? (pipe_sel ? m_word : array_rdata) : '0;
        checks++;
        if (dq_en !== e_en || dq_out !== e_out) begin
            failures++;
            $display("FAIL %s t=%0t pipe=%0b en=%0b/%0b out=%h/%h (actual/expected)",
                     tag, $time, pipe_sel, dq_en, e_en, dq_out, e_out);
        end
    endtask

    // drive at falling edge, compare, then advance through a rising edge
    task automatic step(input logic [1:0] c, input logic [W-1:0] d,
                        input logic o, input logic s, input string tag);
        cmd = c; array_rdata = d; oe = o; sleep = s;
        #1;
        compare(tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n = 1'b0; pipe_sel = mode; cmd = 2'b00; oe = 1'b1; sleep = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        #1;
        compare("R1");
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic run_mode(input logic mode);
        logic [15:0] lf;
        do_reset(mode);
        step(2'b00, 36'h0_1111_1111, 1, 0, "R1");
        // burst of four reads then deselects
        step(2'b01, 36'h0_2222_2222, 1, 0, "R4");
        step(2'b01, 36'h1_A0A0_0001, 1, 0, mode ? "R3" : "R2");
        step(2'b01, 36'h2_B0B0_0002, 1, 0, "R4");
        step(2'b01, 36'h3_C0C0_0003, 1, 0, "R4");
        step(2'b00, 36'h4_D0D0_0004, 1, 0, mode ? "R5" : "R2");
        step(2'b11, 36'h5_E0E0_0005, 1, 0, mode ? "R5" : "R2");
        step(2'b00, 36'h6_F0F0_0006, 1, 0, "R5");
        // read then write immediately
        step(2'b01, 36'h7_0000_0007, 1, 0, "R6");
        step(2'b10, 36'h8_0000_0008, 1, 0, "R6");
        step(2'b01, 36'h9_0000_0009, 1, 0, "R6");
        step(2'b01, 36'hA_0000_000A, 1, 0, "R6");
        step(2'b00, 36'hB_0000_000B, 1, 0, "R6");
        // oe dropped in mid stream, then restored
        step(2'b01, 36'hC_0000_000C, 1, 0, "R7");
        step(2'b01, 36'hD_0000_000D, 0, 0, "R7");
        step(2'b01, 36'hE_0000_000E, 0, 0, "R7");
        step(2'b00, 36'hF_0000_000F, 1, 0, "R7");
        step(2'b00, 36'h0_1234_5678, 1, 0, "R9");
        // one-edge sleep during reads, then release
        step(2'b01, 36'h1_0000_0101, 1, 0, "R8");
        step(2'b01, 36'h2_0000_0102, 1, 1, "R8");
        step(2'b00, 36'h3_0000_0103, 1, 0, "R8");
        step(2'b00, 36'h4_0000_0104, 1, 0, "R8");
        // longer sleep with reads ignored
        step(2'b01, 36'h5_0000_0105, 1, 1, "R8");
        step(2'b01, 36'h6_0000_0106, 1, 1, "R8");
        step(2'b01, 36'h7_0000_0107, 1, 0, "R8");
        step(2'b01, 36'h8_0000_0108, 1, 0, "R8");
        step(2'b00, 36'h9_0000_0109, 1, 0, "R8");
        step(2'b00, 36'hA_0000_010A, 1, 0, "R8");
        // mixed stream
        lf = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[1:0], {lf[3:0], lf, lf},
                 (lf[7:4] != 4'h0), (lf[11:8] == 4'h5), "R4");
        end
        step(2'b00, 36'h0, 1, 0, "R9");
        step(2'b00, 36'h0, 1, 0, "R9");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        model_clear();
        run_mode(1'b1);
        run_mode(1'b0);
        run_mode(1'b1);
        finish_run();
    end

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog expired at t=%0t", $time);
        finish_run();
    end
endmodule